// File: doc/BRIEF.md
# Flash Read-Configuration Register Pair

This block keeps the read-configuration byte of a serial NOR flash in two copies. One copy stands for the non-volatile setting that survives power loss. The other is the volatile working copy, and every live output is decoded from it. A power-up or reset load strobe copies the non-volatile byte into the working copy. After a load, the two copies are changed on their own by decoded set-parameter opcodes. A write goes through only while the write-enable latch is set, and each accepted write asks for that latch to be cleared.

From the working copy the block decodes three things. The first is the number of read dummy cycles. The second is the wrap-around setting, either wrap over the whole array or wrap over a fixed burst length. The third is the role of the shared HOLD/RESET/IO3 pin, which depends on quad enable, QPI mode, the reset-disable setting and whether the package has a dedicated reset pin. The decoded outputs are registered, so they appear one clock after their inputs change. Both copies can be read back at all times.

Top module: `rdcfg_regpair`

## Requirements
- R1: While `rst` is high, both copies are set to the parameter `NV_INIT` (default 8'h00) and `wel_clr` is 0.
- R2: When opcode 8'h65 is presented with `op_valid=1`, `wel=1` and `load_strobe=0`, the non-volatile copy takes `op_data` on the next clock. The working copy stays unchanged until a later load.
- R3: Opcodes 8'hC0 and 8'h63 both write `op_data` into the working copy on the next clock, under the same conditions as R2. The non-volatile copy stays unchanged.
- R4: A `load_strobe` copies the non-volatile byte into the working copy on the next clock. It has priority: any write presented in the same cycle is dropped and does not pulse `wel_clr`.
- R5: With `wel=0`, or with any opcode other than 8'h65, 8'hC0 or 8'h63, neither copy changes and `wel_clr` stays 0.
- R6: Each accepted write drives `wel_clr` high for exactly the one cycle that follows it.
- R7: `dummy_cycles` equals working bits [6:3] (1 to 15). A field value of 0 gives the parameter `DEF_DUMMY` (default 8). Decoded outputs lag the working copy by one clock.
- R8: When working bit 2 is 0, `wrap_en=0` and `burst_len=0`, whatever bits [1:0] hold. When working bit 2 is 1, `wrap_en=1` and `burst_len` is 8, 16, 32 or 64 for bits [1:0] = 00, 01, 10 or 11.
- R9: `pin_role` is encoded as 0 = HOLD, 1 = RESET and 2 = IO3. When `quad_en=1` or `qpi_mode=1`, the role is IO3 and working bit 7 is ignored.
- R10: In SPI mode with `quad_en=0` and `dedicated_rst=1`, the role is HOLD whatever bit 7 holds.
- R11: In SPI mode with `quad_en=0` and `dedicated_rst=0`, the role follows bit 7 when `rst_disable=1` (0 gives HOLD, 1 gives RESET). When `rst_disable=0`, the role is HOLD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_strobe | input | 1 | Power-up/reset load of working copy from non-volatile copy |
| op_valid | input | 1 | Decoded opcode and data are valid this cycle |
| op_code | input | 8 | Decoded opcode |
| op_data | input | 8 | Data byte of the opcode |
| wel | input | 1 | Write-enable latch state |
| quad_en | input | 1 | Quad enable setting |
| qpi_mode | input | 1 | Device is in QPI mode |
| rst_disable | input | 1 | Reset-disable setting from the function register |
| dedicated_rst | input | 1 | Package has a dedicated reset pin |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| dummy_cycles | output | 4 | Read dummy-cycle count |
| wrap_en | output | 1 | Burst wrap enabled |
| burst_len | output | BL_W (7) | Wrap length in bytes, 0 when wrapping over the whole array |
| pin_role | output | 2 | Shared pin role: 0 HOLD, 1 RESET, 2 IO3 |
| nv_q | output | 8 | Non-volatile copy readback |
| vol_q | output | 8 | Working copy readback |

## Verification
Several properties are checked on every cycle:
- IO3 takes precedence whenever quad or QPI mode is on.
- A dedicated-reset package forces HOLD in SPI mode.
- A load copies the non-volatile byte into the working copy.
- A non-volatile write leaves the working copy untouched.
- Nothing changes without the write-enable latch, and the latch-clear pulse follows exactly the accepted writes.
- An active wrap yields a single power-of-two length.

Other behaviour needs the bench scenarios to show it, because it depends on the exact byte values:
- the exact dummy-count mapping, including the zero-means-default case;
- the specific burst lengths;
- the bit-7 selection under the reset-disable setting;
- the drop of a write that collides with a load.

// File: rtl/rdcfg_pkg.sv
package rdcfg_pkg;

  localparam int CFG_W = 8;

  localparam logic [7:0] OP_SET_NV = 8'h65;
  localparam int N_VOL_OPS = 2;
  localparam logic [7:0] VOL_OPS [N_VOL_OPS] = '{8'hC0, 8'h63};

  // field positions inside the configuration byte
  localparam int PIN_SEL_BIT = 7;
  localparam int DUMMY_HI = 6;
  localparam int DUMMY_LO = 3;
  localparam int WRAP_BIT = 2;
  localparam int BURST_HI = 1;
  localparam int BURST_LO = 0;
  localparam int DUMMY_W = DUMMY_HI - DUMMY_LO + 1;
  localparam int BURST_SEL_W = BURST_HI - BURST_LO + 1;
  localparam int N_BURST = 1 << BURST_SEL_W;

  typedef enum logic [1:0] {
    ROLE_HOLD  = 2'd0,
    ROLE_RESET = 2'd1,
    ROLE_IO3   = 2'd2
  } pin_role_e;

endpackage

// File: rtl/rdcfg_store.sv
module rdcfg_store
  import rdcfg_pkg::*;
#(
  parameter logic [CFG_W-1:0] NV_INIT = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_strobe,
  input  logic             op_valid,
  input  logic [7:0]       op_code,
  input  logic [CFG_W-1:0] op_data,
  input  logic             wel,
  output logic [CFG_W-1:0] nv_q,
  output logic [CFG_W-1:0] vol_q,
  output logic             wel_clr
);

  logic [N_VOL_OPS-1:0] vol_hit_vec;
  logic hit_nv, hit_vol, wr_ok;

  genvar gi;
  generate
    for (gi = 0; gi < N_VOL_OPS; gi++) begin : g_volop
      assign vol_hit_vec[gi] = (op_code == VOL_OPS[gi]);
    end
  endgenerate

  always_comb begin
    hit_nv  = op_valid && (op_code == OP_SET_NV);
    hit_vol = op_valid && (|vol_hit_vec);
    wr_ok   = wel && !load_strobe;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nv_q    <= NV_INIT;
      vol_q   <= NV_INIT;
      wel_clr <= 1'b0;
    end else begin
      wel_clr <= wr_ok && (hit_nv || hit_vol);
      if (load_strobe) begin
        vol_q <= nv_q;
      end else if (wr_ok) begin
        if (hit_nv)  nv_q  <= op_data;
        if (hit_vol) vol_q <= op_data;
      end
    end
  end

endmodule

// File: rtl/rdcfg_decode.sv
module rdcfg_decode
  import rdcfg_pkg::*;
#(
  parameter int DEF_DUMMY  = 8,
  parameter int BURST_BASE = 8,
  parameter int BL_W       = 7
) (
  input  logic [CFG_W-1:0]   cfg,
  input  logic               quad_en,
  input  logic               qpi_mode,
  input  logic               rst_disable,
  input  logic               dedicated_rst,
  output logic [DUMMY_W-1:0] dummy,
  output logic               wrap_en,
  output logic [BL_W-1:0]    burst_len,
  output pin_role_e          role
);

  logic [BL_W-1:0] len_tab [N_BURST];

  genvar gi;
  generate
    for (gi = 0; gi < N_BURST; gi++) begin : g_len
      assign len_tab[gi] = BL_W'(BURST_BASE << gi);
    end
  endgenerate

  logic [DUMMY_W-1:0] dfield;
  logic [BURST_SEL_W-1:0] bsel;

  always_comb begin
    dfield  = cfg[DUMMY_HI:DUMMY_LO];
    bsel    = cfg[BURST_HI:BURST_LO];
    dummy   = (dfield == '0) ? DUMMY_W'(DEF_DUMMY) : dfield;
    wrap_en = cfg[WRAP_BIT];
    burst_len = wrap_en ? len_tab[bsel] : '0;

    if (quad_en || qpi_mode)
      role = ROLE_IO3;
    else if (dedicated_rst || !rst_disable)
      role = ROLE_HOLD;
    else
      role = cfg[PIN_SEL_BIT] ? ROLE_RESET : ROLE_HOLD;
  end

endmodule

// File: rtl/rdcfg_regpair.sv
module rdcfg_regpair
  import rdcfg_pkg::*;
#(
  parameter logic [7:0] NV_INIT    = 8'h00,
  parameter int         DEF_DUMMY  = 8,
  parameter int         BURST_BASE = 8,
  localparam int        BL_W       = $clog2(BURST_BASE * (1 << 2) * 2 + 1) - 1 + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_strobe,
  input  logic            op_valid,
  input  logic [7:0]      op_code,
  input  logic [7:0]      op_data,
  input  logic            wel,
  input  logic            quad_en,
  input  logic            qpi_mode,
  input  logic            rst_disable,
  input  logic            dedicated_rst,
  output logic            wel_clr,
  output logic [3:0]      dummy_cycles,
  output logic            wrap_en,
  output logic [BL_W-1:0] burst_len,
  output logic [1:0]      pin_role,
  output logic [7:0]      nv_q,
  output logic [7:0]      vol_q
);

  logic [DUMMY_W-1:0] dec_dummy;
  logic               dec_wrap;
  logic [BL_W-1:0]    dec_len;
  pin_role_e          dec_role;

  rdcfg_store #(.NV_INIT(NV_INIT)) u_store (
    .clk(clk), .rst(rst), .load_strobe(load_strobe),
    .op_valid(op_valid), .op_code(op_code), .op_data(op_data), .wel(wel),
    .nv_q(nv_q), .vol_q(vol_q), .wel_clr(wel_clr)
  );

  rdcfg_decode #(.DEF_DUMMY(DEF_DUMMY), .BURST_BASE(BURST_BASE), .BL_W(BL_W)) u_dec (
    .cfg(vol_q), .quad_en(quad_en), .qpi_mode(qpi_mode),
    .rst_disable(rst_disable), .dedicated_rst(dedicated_rst),
    .dummy(dec_dummy), .wrap_en(dec_wrap), .burst_len(dec_len), .role(dec_role)
  );

  // decoded outputs follow the working copy continuously, reset included
  always_ff @(posedge clk) begin
    dummy_cycles <= dec_dummy;
    wrap_en      <= dec_wrap;
    burst_len    <= dec_len;
    pin_role     <= dec_role;
  end

endmodule

// File: rtl/rdcfg_regpair_chk.sv
module rdcfg_regpair_chk #(
  parameter int BL_W = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            load_strobe,
  input logic            op_valid,
  input logic [7:0]      op_code,
  input logic            wel,
  input logic            quad_en,
  input logic            qpi_mode,
  input logic            dedicated_rst,
  input logic            wel_clr,
  input logic            wrap_en,
  input logic [BL_W-1:0] burst_len,
  input logic [1:0]      pin_role,
  input logic [7:0]      nv_q,
  input logic [7:0]      vol_q
);

  logic wr_code, accepted;
  always_comb begin
    wr_code  = (op_code == 8'h65) || (op_code == 8'hC0) || (op_code == 8'h63);
    accepted = op_valid && wel && !load_strobe && wr_code;
  end

  AST_IO3_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (quad_en || qpi_mode) |=> (pin_role == 2'd2)); // R9
  AST_DEDICATED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!quad_en && !qpi_mode && dedicated_rst) |=> (pin_role == 2'd0)); // R10
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    load_strobe |=> (vol_q == $past(nv_q))); // R4
  AST_NV_KEEPS_VOL: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 8'h65 && !load_strobe) |=> $stable(vol_q)); // R2
  AST_NO_WEL_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!wel && !load_strobe) |=> ($stable(nv_q) && $stable(vol_q))); // R5
  AST_WELCLR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    accepted |=> wel_clr); // R6
  AST_WELCLR_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !accepted |=> !wel_clr); // R6
  AST_WRAP_ONE_LEN: assert property (@(posedge clk) disable iff (rst)
    wrap_en |-> ($countones(burst_len) == 1)); // R8

endmodule

bind rdcfg_regpair rdcfg_regpair_chk #(.BL_W(BL_W)) u_chk (
  .clk(clk), .rst(rst), .load_strobe(load_strobe), .op_valid(op_valid),
  .op_code(op_code), .wel(wel), .quad_en(quad_en), .qpi_mode(qpi_mode),
  .dedicated_rst(dedicated_rst), .wel_clr(wel_clr), .wrap_en(wrap_en),
  .burst_len(burst_len), .pin_role(pin_role), .nv_q(nv_q), .vol_q(vol_q)
);

// File: tb/sim_rdcfg_regpair.sv
`timescale 1ns/1ps
module sim_rdcfg_regpair;

  logic clk = 1'b0;
  logic rst, load_strobe, op_valid, wel;
  logic [7:0] op_code, op_data;
  logic quad_en, qpi_mode, rst_disable, dedicated_rst;
  logic wel_clr, wrap_en;
  logic [3:0] dummy_cycles;
  logic [6:0] burst_len;
  logic [1:0] pin_role;
  logic [7:0] nv_q, vol_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rdcfg_regpair u0 (
    .clk(clk), .rst(rst), .load_strobe(load_strobe), .op_valid(op_valid),
    .op_code(op_code), .op_data(op_data), .wel(wel), .quad_en(quad_en),
    .qpi_mode(qpi_mode), .rst_disable(rst_disable), .dedicated_rst(dedicated_rst),
    .wel_clr(wel_clr), .dummy_cycles(dummy_cycles), .wrap_en(wrap_en),
    .burst_len(burst_len), .pin_role(pin_role), .nv_q(nv_q), .vol_q(vol_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one-cycle command; returns at the negedge after the capturing edge
  task automatic cmd(input logic [7:0] code, input logic [7:0] data, input logic w, input logic ld);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; op_data = data; wel = w; load_strobe = ld;
    @(negedge clk);
    op_valid = 1'b0; wel = 1'b0; load_strobe = 1'b0; op_code = 8'h00;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "nv_q", nv_q, 8'h00);
    chk("R1", "vol_q", vol_q, 8'h00);
    chk("R1", "wel_clr", wel_clr, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_nv_write();
    cmd(8'h65, 8'hAB, 1'b1, 1'b0);
    chk("R2", "nv_q after 65h", nv_q, 8'hAB);
    chk("R2", "vol_q untouched", vol_q, 8'h00);
    chk("R6", "wel_clr pulse", wel_clr, 1);
    @(negedge clk);
    chk("R6", "wel_clr one cycle", wel_clr, 0);
    chk("R2", "vol_q still untouched", vol_q, 8'h00);
  endtask

  task automatic t_vol_write();
    cmd(8'hC0, 8'h5C, 1'b1, 1'b0);
    chk("R3", "vol_q after C0h", vol_q, 8'h5C);
    chk("R3", "nv_q kept", nv_q, 8'hAB);
    cmd(8'h63, 8'h31, 1'b1, 1'b0);
    chk("R3", "vol_q after 63h", vol_q, 8'h31);
    chk("R3", "nv_q kept 63h", nv_q, 8'hAB);
  endtask

  task automatic t_wel_gate();
    cmd(8'hC0, 8'hFF, 1'b0, 1'b0);
    chk("R5", "vol_q no wel", vol_q, 8'h31);
    chk("R5", "wel_clr no wel", wel_clr, 0);
    cmd(8'h65, 8'h11, 1'b0, 1'b0);
    chk("R5", "nv_q no wel", nv_q, 8'hAB);
    cmd(8'h06, 8'h77, 1'b1, 1'b0);
    chk("R5", "vol_q other op", vol_q, 8'h31);
    chk("R5", "nv_q other op", nv_q, 8'hAB);
    chk("R5", "wel_clr other op", wel_clr, 0);
  endtask

  task automatic t_load();
    cmd(8'h00, 8'h00, 1'b0, 1'b1);
    chk("R4", "vol_q loaded", vol_q, 8'hAB);
    // collision: load wins, write dropped
    cmd(8'h65, 8'h42, 1'b1, 1'b0);
    cmd(8'hC0, 8'h99, 1'b1, 1'b1);
    chk("R4", "vol_q load priority", vol_q, 8'h42);
    chk("R4", "wel_clr on collision", wel_clr, 0);
    cmd(8'h65, 8'h13, 1'b1, 1'b1);
    chk("R4", "nv_q write dropped", nv_q, 8'h42);
  endtask

  task automatic set_vol_and_wait(input logic [7:0] v);
    cmd(8'hC0, v, 1'b1, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_dummy();
    set_vol_and_wait(8'h00);
    chk("R7", "dummy default", dummy_cycles, 8);
    set_vol_and_wait({1'b0, 4'd1, 3'b000});
    chk("R7", "dummy 1", dummy_cycles, 1);
    set_vol_and_wait({1'b0, 4'd15, 3'b000});
    chk("R7", "dummy 15", dummy_cycles, 15);
    set_vol_and_wait({1'b1, 4'd5, 3'b011});
    chk("R7", "dummy 5", dummy_cycles, 5);
  endtask

  task automatic t_wrap();
    set_vol_and_wait(8'b0000_0011);
    chk("R8", "wrap off en", wrap_en, 0);
    chk("R8", "wrap off len", burst_len, 0);
    for (int b = 0; b < 4; b++) begin
      set_vol_and_wait({5'b00000, 1'b1, 2'(b)});
      chk("R8", "wrap on en", wrap_en, 1);
      chk("R8", "burst len", burst_len, 8 << b);
    end
  endtask

  function automatic int exp_role(input bit b7, input bit qe, input bit qpi, input bit rd, input bit ded);
    if (qe || qpi) return 2;
    if (ded) return 0;
    if (!rd) return 0;
    return b7 ? 1 : 0;
  endfunction

  task automatic t_roles();
    for (int b7 = 0; b7 < 2; b7++) begin
      set_vol_and_wait({1'(b7), 7'h00});
      for (int m = 0; m < 16; m++) begin
        @(negedge clk);
        quad_en = m[0]; qpi_mode = m[1]; rst_disable = m[2]; dedicated_rst = m[3];
        @(negedge clk);
        if (m[0] || m[1])
          chk("R9", "role io3", pin_role, exp_role(1'(b7), m[0], m[1], m[2], m[3]));
        else if (m[3])
          chk("R10", "role dedicated", pin_role, exp_role(1'(b7), m[0], m[1], m[2], m[3]));
        else
          chk("R11", "role select", pin_role, exp_role(1'(b7), m[0], m[1], m[2], m[3]));
      end
    end
    quad_en = 1'b0; qpi_mode = 1'b0; rst_disable = 1'b0; dedicated_rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; load_strobe = 1'b0; op_valid = 1'b0; wel = 1'b0;
    op_code = 8'h00; op_data = 8'h00;
    quad_en = 1'b0; qpi_mode = 1'b0; rst_disable = 1'b0; dedicated_rst = 1'b0;
    t_reset();
    t_nv_write();
    t_vol_write();
    t_wel_gate();
    t_load();
    t_dummy();
    t_wrap();
    t_roles();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule